// File: doc/BRIEF.md
# Fractional-Nanosecond Time-of-Day Clock

This block is a free-running time-of-day counter for precision time hardware. It keeps two timestamps. The split timestamp holds whole seconds in its upper 48 bits. Its lower 48 bits hold nanoseconds scaled by 2^16, so the lowest 16 bits are fractions of a nanosecond. The flat timestamp is a single 64-bit count of nanoseconds scaled by 2^16, with no seconds field.

On every clock cycle both timestamps advance by a programmable step. The step is a whole-nanosecond count plus a 16-bit fraction. For example, a 6.4 ns clock uses 6 and 0x6666. A drift correction can be added once every N cycles, which gives a long-run average step finer than 2^-16 ns. When the scaled nanosecond field of the split timestamp reaches one second, it wraps and carries into the seconds field, and the block raises a one-cycle pulse-per-second strobe.

Either timestamp can be loaded through its own strobe. When this happens, a one-cycle step flag marks the discontinuity. Step and drift settings can change at any time and take effect without disturbing the timestamps.

Top module: `frac_tod_clock`

## Requirements
- R1: While `rst` is high at a clock edge, both timestamps, `step_out` and `pps_out` become zero, and so does the drift cycle counter.
- R2: Without a load or a drift injection, each cycle both timestamps increase by `period_ns*65536 + period_fns`. `tod_out[95:48]` is seconds and `tod_out[47:0]` is nanoseconds times 65536. `flat_out` is a plain 64-bit scaled-nanosecond count that wraps modulo 2^64.
- R3: With `drift_rate` = N > 0, an internal counter steps 0,1,…,N-1 and then restarts at 0. In the cycle it sits at N-1 (or above, after N has been lowered), the step taken is larger by `drift_ns*65536 + drift_fns`. After reset, the first injection therefore lands on the Nth cycle.
- R4: A `drift_rate` of 0 disables drift injection and holds the counter at 0, whatever the drift values are.
- R5: When the scaled nanosecond field plus the step reaches 1,000,000,000*65536, that constant is subtracted instead of wrapping to zero, so the fractional remainder is kept. The seconds field also increases by one.
- R6: `pps_out` is high for exactly the one cycle in which the incremented seconds value first appears on `tod_out`.
- R7: A pulse on `load_tod_en` makes the next `tod_out` equal to the loaded seconds and the loaded nanosecond field plus the step of that cycle. No wrap is applied in that cycle and `pps_out` stays low, because the load wins over a rollover. `step_out` is high in that cycle.
- R8: A pulse on `load_flat_en` makes the next `flat_out` equal to `load_flat_val` plus the step of that cycle, and raises `step_out` for that cycle.
- R9: A change to the step or drift settings applies from the next edge on, and neither timestamp jumps.
- R10: `step_out` is low in every cycle that follows an edge with no load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period_ns | input | 8 | Whole nanoseconds per cycle |
| period_fns | input | 16 | Fractional nanoseconds per cycle (units of 2^-16 ns) |
| drift_ns | input | 8 | Whole nanoseconds of the drift correction |
| drift_fns | input | 16 | Fractional nanoseconds of the drift correction |
| drift_rate | input | 16 | Cycles between drift injections; 0 disables them |
| load_tod_en | input | 1 | Load strobe for the split timestamp |
| load_tod_val | input | 96 | Value for the split timestamp |
| load_flat_en | input | 1 | Load strobe for the flat timestamp |
| load_flat_val | input | 64 | Value for the flat timestamp |
| tod_out | output | 96 | Seconds and scaled nanoseconds |
| flat_out | output | 64 | Flat scaled-nanosecond count |
| step_out | output | 1 | High for one cycle after a load |
| pps_out | output | 1 | High for one cycle when seconds increment |

## Verification
The plain 6.4 ns step with drift disabled shows that the basic accumulation is correct in both timestamp formats. A drift of 20 fractional units every 5 cycles and a whole-plus-half nanosecond drift every 3 cycles show where the injection lands and that its whole and fractional parts are weighted correctly. Lowering the rate while the counter sits above the new limit checks the early restart. Turning the rate to zero with nonzero drift values shows that the rate alone gates the injection. Two step values are changed mid-run to confirm that no timestamp jumps. A load just below a second boundary, with a nonzero fraction, separates a correct subtract-and-carry wrap from a reset-to-zero wrap and checks the pulse-per-second timing. A load already past the boundary checks that the load wins over the rollover. A flat load near 2^64 checks the flat wrap.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int FRAC_W = 16;

  // Whole nanoseconds and a 16-bit fraction packed as a scaled-ns quantity.
  function automatic logic [63:0] scaled_ns(input logic [31:0] whole,
                                            input logic [FRAC_W-1:0] frac);
    return (64'(whole) << FRAC_W) | 64'(frac);
  endfunction

  // Step taken in one cycle: the period, plus the drift when injected.
  function automatic logic [63:0] cycle_step(input logic [63:0] period_s,
                                             input logic [63:0] drift_s,
                                             input logic inject);
    return period_s + (inject ? drift_s : 64'd0);
  endfunction
endpackage

// File: rtl/tod_drift_sched.sv
module tod_drift_sched #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  output logic              hit
);
  logic [RATE_W-1:0] cnt_q;
  logic              at_last;

  assign at_last = (rate != '0) && (cnt_q >= rate - 1'b1);
  assign hit     = at_last;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (rate == '0 || at_last) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  // R3
  drift_restart_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt_q == '0));

  // R4
  drift_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == '0) |-> !hit);
endmodule

// File: rtl/tod_split_acc.sv
module tod_split_acc
  import tod_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NSF_W = 48
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSF_W-1:0]       inc,
  input  logic                   load_en,
  input  logic [SEC_W+NSF_W-1:0] load_val,
  output logic [SEC_W+NSF_W-1:0] tod_q,
  output logic                   pps_q,
  output logic                   wrap_evt
);
  localparam int SUMW = NSF_W + 1;
  localparam logic [SUMW-1:0] ONE_SEC = SUMW'(64'd1000000000 << FRAC_W);

  logic [SEC_W-1:0] sec_q;
  logic [NSF_W-1:0] ns_q;
  logic [SUMW-1:0]  ns_sum;
  logic [NSF_W-1:0] ns_less;

  assign ns_sum   = {1'b0, ns_q} + {1'b0, inc};
  assign ns_less  = ns_sum[NSF_W-1:0] - ONE_SEC[NSF_W-1:0];
  assign wrap_evt = !load_en && (ns_sum >= ONE_SEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      ns_q  <= '0;
      pps_q <= 1'b0;
    end else if (load_en) begin
      sec_q <= load_val[SEC_W+NSF_W-1:NSF_W];
      ns_q  <= load_val[NSF_W-1:0] + inc;
      pps_q <= 1'b0;
    end else if (wrap_evt) begin
      sec_q <= sec_q + 1'b1;
      ns_q  <= ns_less;
      pps_q <= 1'b1;
    end else begin
      ns_q  <= ns_sum[NSF_W-1:0];
      pps_q <= 1'b0;
    end
  end

  assign tod_q = {sec_q, ns_q};

  // R6
  wrap_pps_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> pps_q);

  // R5
  pps_carry_chk: assert property (@(posedge clk) disable iff (rst)
    pps_q |-> (sec_q == SEC_W'($past(sec_q) + 1'b1)));

  // R7
  load_no_pps_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> !pps_q);
endmodule

// File: rtl/tod_flat_acc.sv
module tod_flat_acc #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] inc,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] flat_q
);
  always_ff @(posedge clk) begin
    if (rst)          flat_q <= '0;
    else if (load_en) flat_q <= load_val + inc;
    else              flat_q <= flat_q + inc;
  end

  // R2
  flat_advance_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> (flat_q == W'($past(flat_q) + $past(inc))));
endmodule

// File: rtl/frac_tod_clock.sv
module frac_tod_clock
  import tod_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NSF_W      = 48,
  parameter int FLAT_W     = 64,
  parameter int PER_NS_W   = 8,
  parameter int DRIFT_NS_W = 8,
  parameter int RATE_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PER_NS_W-1:0]    period_ns,
  input  logic [FRAC_W-1:0]      period_fns,
  input  logic [DRIFT_NS_W-1:0]  drift_ns,
  input  logic [FRAC_W-1:0]      drift_fns,
  input  logic [RATE_W-1:0]      drift_rate,
  input  logic                   load_tod_en,
  input  logic [SEC_W+NSF_W-1:0] load_tod_val,
  input  logic                   load_flat_en,
  input  logic [FLAT_W-1:0]      load_flat_val,
  output logic [SEC_W+NSF_W-1:0] tod_out,
  output logic [FLAT_W-1:0]      flat_out,
  output logic                   step_out,
  output logic                   pps_out
);
  logic              drift_hit;
  logic              wrap_evt;
  logic              any_load;
  logic              step_q;
  logic [FLAT_W-1:0] step_inc;

  assign step_inc = FLAT_W'(cycle_step(scaled_ns(32'(period_ns), period_fns),
                                       scaled_ns(32'(drift_ns), drift_fns),
                                       drift_hit));
  assign any_load = load_tod_en || load_flat_en;

  tod_drift_sched #(.RATE_W(RATE_W)) u_sched (
    .clk  (clk),
    .rst  (rst),
    .rate (drift_rate),
    .hit  (drift_hit)
  );

  tod_split_acc #(.SEC_W(SEC_W), .NSF_W(NSF_W)) u_split (
    .clk      (clk),
    .rst      (rst),
    .inc      (step_inc[NSF_W-1:0]),
    .load_en  (load_tod_en),
    .load_val (load_tod_val),
    .tod_q    (tod_out),
    .pps_q    (pps_out),
    .wrap_evt (wrap_evt)
  );

  tod_flat_acc #(.W(FLAT_W)) u_flat (
    .clk      (clk),
    .rst      (rst),
    .inc      (step_inc),
    .load_en  (load_flat_en),
    .load_val (load_flat_val),
    .flat_q   (flat_out)
  );

  always_ff @(posedge clk) begin
    if (rst) step_q <= 1'b0;
    else     step_q <= any_load;
  end
  assign step_out = step_q;

  // R8
  load_step_chk: assert property (@(posedge clk) disable iff (rst)
    any_load |=> step_out);

  // R10
  quiet_step_chk: assert property (@(posedge clk) disable iff (rst)
    !any_load |=> !step_out);

  // R6
  pps_single_chk: assert property (@(posedge clk) disable iff (rst)
    pps_out |=> !pps_out || $past(wrap_evt));
endmodule

// File: tb/tb_frac_tod_clock.sv
module tb_frac_tod_clock;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [48:0] ONE_S = 49'd65536000000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  period_ns = 8'd6;
  logic [15:0] period_fns = 16'h6666;
  logic [7:0]  drift_ns = '0;
  logic [15:0] drift_fns = '0;
  logic [15:0] drift_rate = '0;
  logic        load_tod_en = 1'b0;
  logic [95:0] load_tod_val = '0;
  logic        load_flat_en = 1'b0;
  logic [63:0] load_flat_val = '0;
  logic [95:0] tod_out;
  logic [63:0] flat_out;
  logic        step_out, pps_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_tod_clock dut (
    .clk(clk), .rst(rst),
    .period_ns(period_ns), .period_fns(period_fns),
    .drift_ns(drift_ns), .drift_fns(drift_fns), .drift_rate(drift_rate),
    .load_tod_en(load_tod_en), .load_tod_val(load_tod_val),
    .load_flat_en(load_flat_en), .load_flat_val(load_flat_val),
    .tod_out(tod_out), .flat_out(flat_out),
    .step_out(step_out), .pps_out(pps_out)
  );

  typedef struct {
    logic [95:0] tod;
    logic [63:0] flat;
    logic        step;
    logic        pps;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  // reference state
  logic [47:0] m_sec = '0;
  logic [47:0] m_ns = '0;
  logic [63:0] m_flat = '0;
  int          m_since = 0;

  // Driver side: work out the next outputs from the requirements and queue them.
  task automatic tick(input string tag);
    exp_t e;
    logic [63:0] inc;
    logic [48:0] s;
    bit          inject;
    inject = (drift_rate != 0) && (m_since + 1 >= int'(drift_rate));
    inc = 64'(period_ns) * 64'd65536 + 64'(period_fns);
    if (inject) inc = inc + 64'(drift_ns) * 64'd65536 + 64'(drift_fns);
    m_since = (drift_rate == 0 || inject) ? 0 : m_since + 1;
    e.pps = 1'b0;
    if (load_tod_en) begin
      m_sec = load_tod_val[95:48];
      m_ns  = load_tod_val[47:0] + inc[47:0];
    end else begin
      s = {1'b0, m_ns} + {1'b0, inc[47:0]};
      if (s >= ONE_S) begin
        s = s - ONE_S;
        m_sec = m_sec + 48'd1;
        e.pps = 1'b1;
      end
      m_ns = s[47:0];
    end
    m_flat = load_flat_en ? load_flat_val + inc : m_flat + inc;
    e.tod  = {m_sec, m_ns};
    e.flat = m_flat;
    e.step = load_tod_en || load_flat_en;
    e.tag  = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor side: pop and compare after each edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (tod_out !== e.tod || flat_out !== e.flat ||
          step_out !== e.step || pps_out !== e.pps) begin
        errors++;
        $display("FAIL %s: tod=%h flat=%h step=%b pps=%b expected tod=%h flat=%h step=%b pps=%b",
                 e.tag, tod_out, flat_out, step_out, pps_out,
                 e.tod, e.flat, e.step, e.pps);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (tod_out !== '0 || flat_out !== '0 || step_out !== 1'b0 || pps_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: tod=%h flat=%h step=%b pps=%b expected all zero",
               tod_out, flat_out, step_out, pps_out);
    end
    rst = 1'b0;

    // R2: plain 6.4 ns step, no drift
    repeat (30) tick("R2");

    // R3: small fractional drift every 5 cycles
    drift_ns = 8'd0; drift_fns = 16'd20; drift_rate = 16'd5;
    repeat (30) tick("R3");
    // R3: whole-plus-fraction drift every 3 cycles
    drift_ns = 8'd1; drift_fns = 16'h8000; drift_rate = 16'd3;
    repeat (12) tick("R3");
    // R3: lower the rate while counter sits high
    drift_rate = 16'd7;
    repeat (5) tick("R3");
    drift_rate = 16'd2;
    repeat (8) tick("R3");

    // R4: rate zero with nonzero drift values
    drift_ns = 8'd3; drift_fns = 16'd5; drift_rate = 16'd0;
    repeat (15) tick("R4");

    // R9: run-time step changes
    period_ns = 8'd7; period_fns = 16'h0001;
    repeat (10) tick("R9");
    period_ns = 8'd6; period_fns = 16'h6624;
    repeat (10) tick("R9");

    // R7 then R5/R6: load just below a second boundary with a fraction
    load_tod_en = 1'b1;
    load_tod_val = {48'd5, (48'd999999980 << 16) | 48'h1234};
    tick("R7");
    load_tod_en = 1'b0;
    repeat (6) tick("R5");
    repeat (4) tick("R6");

    // R7: load already past the boundary; load wins, wrap on next cycle
    load_tod_en = 1'b1;
    load_tod_val = {48'd9, 48'd999999999 << 16};
    tick("R7");
    load_tod_en = 1'b0;
    repeat (3) tick("R5");

    // R8: flat load near 2^64, together with a split load
    load_flat_en = 1'b1;
    load_flat_val = 64'hFFFF_FFFF_FFFF_0000;
    load_tod_en = 1'b1;
    load_tod_val = {48'd2, 48'd100 << 16};
    tick("R8");
    load_flat_en = 1'b0;
    load_tod_en = 1'b0;
    repeat (5) tick("R10");

    // R3: drift again after loads
    drift_ns = 8'd0; drift_fns = 16'd7; drift_rate = 16'd4;
    repeat (10) tick("R3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule